// File: doc/BRIEF.md
# Link Credit Gate

This block keeps a transmitter from overrunning the buffers at the far end of a serial point-to-point link, for one virtual channel. Both directions share a single clock. Credits come in two independent pools. One pool counts packet headers and the other counts payload data, where one data credit covers 16 bytes.

On the transmit side, the block holds a running count of the credits spent and the most recent credit limit the far end has granted. It raises `txReady` for a pending request only when both pools can cover that request. It charges the credits on the same cycle the request goes out.

On the receive side, the block counts the credits taken by arriving packets. It also counts the credits it has offered, which grow as the local consumer frees buffer space. Whenever that offered total changes, the block raises an update strobe carrying the new totals, and these become the far end's limit.

All counters wrap freely. The test for whether a request fits uses modular distance. A gap of half the counter range or less counts as room. A larger gap means the request would overrun.

Top module: `link_credit_gate`

## Requirements
- R1: While reset is asserted and after its release, the spent and granted-limit counters are zero, so `txHdrAvail` = 0, `txDatAvail` = 0 and `txReady` = 0. The received counters are zero. `rxHdrLimitOut`/`rxDatLimitOut` equal the configured capacities `HDR_CAP`/`DAT_CAP`.
- R2: A cycle with `updValid` high loads `updHdrLimit`/`updDatLimit` as the new granted limits. From the next cycle on, `txHdrAvail` = limit − spent and `txDatAvail` = limit − spent, each modulo 2^width.
- R3: `txReady` is high exactly when `txReqValid` is high and both pools fit. A pool fits when (limit − (spent + needed)) mod 2^width ≤ 2^(width−1). Header counters are 8 bits and data counters are 12 bits.
- R4: A request is sent in any cycle where `txReqValid` and `txReady` are both high. A sent request adds 1 to header spent and ceil(`txReqBytes`/16) to data spent. A request held with `txReady` low changes neither count.
- R5: A request with `txReqBytes` = 0 needs 0 data credits but still needs 1 header credit.
- R6: When a send and `updValid` occur in the same cycle, both take effect. The readiness of that send is judged against the limit held before the update.
- R7: Spent, limit, received and offered counters all wrap modulo 2^width with no saturation.
- R8: A cycle with `rxPktValid` high adds 1 to `rxHdrRcvd` and ceil(`rxPktBytes`/16) to `rxDatRcvd`.
- R9: A cycle with `rxFreeValid` high adds `rxFreeHdr`/`rxFreeDat` to the offered totals on `rxHdrLimitOut`/`rxDatLimitOut`. `rxUpdValid` is high in the following cycle only when at least one of those amounts is non-zero; otherwise it is low.
- R10: `rxUpdValid` is high from reset until the first clock edge after reset release, so the far end receives the initial capacities.
- R11: Starting from reset, grant 4 header and 40 data credits, then send two requests of 160 bytes each. Both sends are accepted, and 2 header and 20 data credits then remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txReqValid | input | 1 | A request is pending |
| txReqBytes | input | LEN_W | Payload size of the pending request, in bytes |
| txReady | output | 1 | The pending request is sent this cycle |
| updValid | input | 1 | Credit-limit update from the far end |
| updHdrLimit | input | HDR_W | New header credit limit |
| updDatLimit | input | DAT_W | New data credit limit |
| txHdrAvail | output | HDR_W | Header limit minus header spent |
| txDatAvail | output | DAT_W | Data limit minus data spent |
| rxPktValid | input | 1 | An incoming packet is taken into the buffer |
| rxPktBytes | input | LEN_W | Payload size of the incoming packet, in bytes |
| rxFreeValid | input | 1 | The consumer frees buffer space |
| rxFreeHdr | input | HDR_W | Header credits freed |
| rxFreeDat | input | DAT_W | Data credits freed |
| rxUpdValid | output | 1 | The offered totals have changed and must be sent |
| rxHdrLimitOut | output | HDR_W | Header credits offered so far |
| rxDatLimitOut | output | DAT_W | Data credits offered so far |
| rxHdrRcvd | output | HDR_W | Header credits received so far |
| rxDatRcvd | output | DAT_W | Data credits received so far |

## Verification
The hardest situations to reach are the edge of the modular window and the wrap of the spent counters past zero. Both need hundreds or thousands of sends with limits that keep moving.

The bench sweeps the header limit over every offset from the spent count, and the data limit across both ends of its half-range. It then sends every payload size from 0 to 4095 bytes back to back, each with a fresh update in the same cycle. This drives both spent counters through several wraps while same-cycle send and update occur on every step.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

  typedef struct packed {
    logic consume;
    logic loadLimit;
    logic receive;
    logic allocate;
    logic advertise;
  } lcgStrobes_t;

endpackage

// File: rtl/lcg_datapath.sv
module lcg_datapath
  import lcg_pkg::*;
#(
  parameter int HDR_W   = 8,
  parameter int DAT_W   = 12,
  parameter int LEN_W   = 12,
  parameter int BPC     = 16,
  parameter int HDR_CAP = 16,
  parameter int DAT_CAP = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  lcgStrobes_t      strb,
  input  logic [LEN_W-1:0] txReqBytes,
  input  logic [HDR_W-1:0] updHdrLimit,
  input  logic [DAT_W-1:0] updDatLimit,
  input  logic [LEN_W-1:0] rxPktBytes,
  input  logic [HDR_W-1:0] rxFreeHdr,
  input  logic [DAT_W-1:0] rxFreeDat,
  output logic             hdrOk,
  output logic             datOk,
  output logic             freeNonZero,
  output logic [HDR_W-1:0] txHdrAvail,
  output logic [DAT_W-1:0] txDatAvail,
  output logic [HDR_W-1:0] rxHdrLimitOut,
  output logic [DAT_W-1:0] rxDatLimitOut,
  output logic [HDR_W-1:0] rxHdrRcvd,
  output logic [DAT_W-1:0] rxDatRcvd
);

  localparam int SHIFT = $clog2(BPC);
  localparam logic [HDR_W:0] HDR_HALF = (HDR_W+1)'(1) << (HDR_W-1);
  localparam logic [DAT_W:0] DAT_HALF = (DAT_W+1)'(1) << (DAT_W-1);
  localparam logic [HDR_W-1:0] HDR_ONE = HDR_W'(1);

  function automatic logic [DAT_W-1:0] creditsFor(input logic [LEN_W-1:0] bytes);
    logic [LEN_W:0] padded;
    padded = {1'b0, bytes} + (LEN_W+1)'(BPC - 1);
    return DAT_W'(padded >> SHIFT);
  endfunction

  logic [HDR_W-1:0] hdrSpent, hdrLimit, hdrAlloc, hdrRcvd;
  logic [DAT_W-1:0] datSpent, datLimit, datAlloc, datRcvd;
  logic [DAT_W-1:0] txNeed, rxNeed;
  logic [HDR_W-1:0] hdrGap;
  logic [DAT_W-1:0] datGap;

  assign txNeed = creditsFor(txReqBytes);
  assign rxNeed = creditsFor(rxPktBytes);

  // modular distance left after taking this request
  assign hdrGap = hdrLimit - (hdrSpent + HDR_ONE);
  assign datGap = datLimit - (datSpent + txNeed);
  assign hdrOk  = {1'b0, hdrGap} <= HDR_HALF;
  assign datOk  = {1'b0, datGap} <= DAT_HALF;

  assign freeNonZero = (rxFreeHdr != '0) || (rxFreeDat != '0);

  // transmit counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrSpent <= '0;
      datSpent <= '0;
      hdrLimit <= '0;
      datLimit <= '0;
    end else begin
      if (strb.consume) begin
        hdrSpent <= hdrSpent + HDR_ONE;
        datSpent <= datSpent + txNeed;
      end
      if (strb.loadLimit) begin
        hdrLimit <= updHdrLimit;
        datLimit <= updDatLimit;
      end
    end
  end

  // receive counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrAlloc <= HDR_W'(HDR_CAP);
      datAlloc <= DAT_W'(DAT_CAP);
      hdrRcvd  <= '0;
      datRcvd  <= '0;
    end else begin
      if (strb.allocate) begin
        hdrAlloc <= hdrAlloc + rxFreeHdr;
        datAlloc <= datAlloc + rxFreeDat;
      end
      if (strb.receive) begin
        hdrRcvd <= hdrRcvd + HDR_ONE;
        datRcvd <= datRcvd + rxNeed;
      end
    end
  end

  assign txHdrAvail    = hdrLimit - hdrSpent;
  assign txDatAvail    = datLimit - datSpent;
  assign rxHdrLimitOut = hdrAlloc;
  assign rxDatLimitOut = datAlloc;
  assign rxHdrRcvd     = hdrRcvd;
  assign rxDatRcvd     = datRcvd;

  // R4: every send charges exactly one header credit
  p_send_one_hdr_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.consume |=> hdrSpent == $past(hdrSpent) + HDR_ONE);

  // R2: an update becomes the granted limit
  p_limit_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadLimit |=> (hdrLimit == $past(updHdrLimit)) && (datLimit == $past(updDatLimit)));

  // R8: each arriving packet takes one header credit
  p_rcv_hdr_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.receive |=> hdrRcvd == $past(hdrRcvd) + HDR_ONE);

  // R9: offered totals move only on a free strobe
  p_alloc_still_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.allocate |=> $stable(hdrAlloc) && $stable(datAlloc));

endmodule

// File: rtl/lcg_ctrl.sv
module lcg_ctrl
  import lcg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txReqValid,
  input  logic        hdrOk,
  input  logic        datOk,
  input  logic        updValid,
  input  logic        rxPktValid,
  input  logic        rxFreeValid,
  input  logic        freeNonZero,
  output lcgStrobes_t strb,
  output logic        txReady,
  output logic        rxUpdValid
);

  logic advPending;

  assign txReady = txReqValid && hdrOk && datOk;

  always_comb begin
    strb           = '0;
    strb.consume   = txReady;
    strb.loadLimit = updValid;
    strb.receive   = rxPktValid;
    strb.allocate  = rxFreeValid;
    strb.advertise = rxFreeValid && freeNonZero;
  end

  // starts set so the capacities go out once after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) advPending <= 1'b1;
    else       advPending <= strb.advertise;
  end

  assign rxUpdValid = advPending;

  // R9: a non-empty free is advertised on the next cycle
  p_adv_after_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFreeValid && freeNonZero) |=> rxUpdValid);

  // R9: no advertisement without a non-empty free
  p_no_idle_adv_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(rxFreeValid && freeNonZero) |=> !rxUpdValid);

endmodule

// File: rtl/link_credit_gate.sv
module link_credit_gate
  import lcg_pkg::*;
#(
  parameter int HDR_W   = 8,
  parameter int DAT_W   = 12,
  parameter int LEN_W   = 12,
  parameter int BPC     = 16,
  parameter int HDR_CAP = 16,
  parameter int DAT_CAP = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txReqValid,
  input  logic [LEN_W-1:0] txReqBytes,
  output logic             txReady,
  input  logic             updValid,
  input  logic [HDR_W-1:0] updHdrLimit,
  input  logic [DAT_W-1:0] updDatLimit,
  output logic [HDR_W-1:0] txHdrAvail,
  output logic [DAT_W-1:0] txDatAvail,
  input  logic             rxPktValid,
  input  logic [LEN_W-1:0] rxPktBytes,
  input  logic             rxFreeValid,
  input  logic [HDR_W-1:0] rxFreeHdr,
  input  logic [DAT_W-1:0] rxFreeDat,
  output logic             rxUpdValid,
  output logic [HDR_W-1:0] rxHdrLimitOut,
  output logic [DAT_W-1:0] rxDatLimitOut,
  output logic [HDR_W-1:0] rxHdrRcvd,
  output logic [DAT_W-1:0] rxDatRcvd
);

  lcgStrobes_t strb;
  logic hdrOk, datOk, freeNonZero;

  lcg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txReqValid  (txReqValid),
    .hdrOk       (hdrOk),
    .datOk       (datOk),
    .updValid    (updValid),
    .rxPktValid  (rxPktValid),
    .rxFreeValid (rxFreeValid),
    .freeNonZero (freeNonZero),
    .strb        (strb),
    .txReady     (txReady),
    .rxUpdValid  (rxUpdValid)
  );

  lcg_datapath #(
    .HDR_W(HDR_W), .DAT_W(DAT_W), .LEN_W(LEN_W), .BPC(BPC),
    .HDR_CAP(HDR_CAP), .DAT_CAP(DAT_CAP)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .txReqBytes    (txReqBytes),
    .updHdrLimit   (updHdrLimit),
    .updDatLimit   (updDatLimit),
    .rxPktBytes    (rxPktBytes),
    .rxFreeHdr     (rxFreeHdr),
    .rxFreeDat     (rxFreeDat),
    .hdrOk         (hdrOk),
    .datOk         (datOk),
    .freeNonZero   (freeNonZero),
    .txHdrAvail    (txHdrAvail),
    .txDatAvail    (txDatAvail),
    .rxHdrLimitOut (rxHdrLimitOut),
    .rxDatLimitOut (rxDatLimitOut),
    .rxHdrRcvd     (rxHdrRcvd),
    .rxDatRcvd     (rxDatRcvd)
  );

  // R4: a held request leaves the available credits untouched
  p_blocked_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txReqValid && !txReady && !updValid) |=> $stable(txHdrAvail) && $stable(txDatAvail));

  // R3: nothing is sent without a pending request
  p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    !txReqValid |-> !txReady);

endmodule

// File: tb/tb_link_credit_gate.sv
module tb_link_credit_gate;

  localparam int HW = 8;
  localparam int DW = 12;
  localparam int LW = 12;
  localparam int HCAP = 16;
  localparam int DCAP = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txReqValid = 1'b0;
  logic [LW-1:0] txReqBytes = '0;
  logic txReady;
  logic updValid = 1'b0;
  logic [HW-1:0] updHdrLimit = '0;
  logic [DW-1:0] updDatLimit = '0;
  logic [HW-1:0] txHdrAvail;
  logic [DW-1:0] txDatAvail;
  logic rxPktValid = 1'b0;
  logic [LW-1:0] rxPktBytes = '0;
  logic rxFreeValid = 1'b0;
  logic [HW-1:0] rxFreeHdr = '0;
  logic [DW-1:0] rxFreeDat = '0;
  logic rxUpdValid;
  logic [HW-1:0] rxHdrLimitOut;
  logic [DW-1:0] rxDatLimitOut;
  logic [HW-1:0] rxHdrRcvd;
  logic [DW-1:0] rxDatRcvd;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [HW-1:0] mHC = '0, mHL = '0, mHA = HW'(HCAP), mHR = '0;
  logic [DW-1:0] mDC = '0, mDL = '0, mDA = DW'(DCAP), mDR = '0;

  always #10 clk = ~clk;

  link_credit_gate #(.HDR_W(HW), .DAT_W(DW), .LEN_W(LW), .BPC(16),
                     .HDR_CAP(HCAP), .DAT_CAP(DCAP)) dut (.*);

  function automatic logic [DW-1:0] need(input int bytes);
    return DW'((bytes + 15) / 16);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one transmit cycle; starts and ends just after a falling edge
  task automatic txStep(input logic v, input int bytes, input logic u,
                        input logic [HW-1:0] hl, input logic [DW-1:0] dl, input string req);
    logic [HW-1:0] gh;
    logic [DW-1:0] gd;
    logic expRdy;
    txReqValid = v; txReqBytes = LW'(bytes);
    updValid = u; updHdrLimit = hl; updDatLimit = dl;
    #1;
    gh = mHL - (mHC + HW'(1));
    gd = mDL - (mDC + need(bytes));
    expRdy = v && ({1'b0, gh} <= 9'd128) && ({1'b0, gd} <= 13'd2048);
    chk(txReady == expRdy, {req, " ready"}, int'(txReady), int'(expRdy));
    @(posedge clk);
    if (expRdy) begin
      mHC = mHC + HW'(1);
      mDC = mDC + need(bytes);
    end
    if (u) begin mHL = hl; mDL = dl; end
    @(negedge clk);
    txReqValid = 1'b0; updValid = 1'b0;
    #1;
    chk(txHdrAvail == HW'(mHL - mHC), {req, " hdr avail"}, int'(txHdrAvail), int'(HW'(mHL - mHC)));
    chk(txDatAvail == DW'(mDL - mDC), {req, " dat avail"}, int'(txDatAvail), int'(DW'(mDL - mDC)));
  endtask

  task automatic rxStep(input logic pv, input int pbytes, input logic fv,
                        input logic [HW-1:0] fh, input logic [DW-1:0] fd, input string req);
    logic expUpd;
    rxPktValid = pv; rxPktBytes = LW'(pbytes);
    rxFreeValid = fv; rxFreeHdr = fh; rxFreeDat = fd;
    @(posedge clk);
    if (pv) begin mHR = mHR + HW'(1); mDR = mDR + need(pbytes); end
    if (fv) begin mHA = mHA + fh; mDA = mDA + fd; end
    expUpd = fv && ((fh != '0) || (fd != '0));
    @(negedge clk);
    rxPktValid = 1'b0; rxFreeValid = 1'b0;
    #1;
    chk(rxHdrRcvd == mHR, {req, " hdr rcvd"}, int'(rxHdrRcvd), int'(mHR));
    chk(rxDatRcvd == mDR, {req, " dat rcvd"}, int'(rxDatRcvd), int'(mDR));
    chk(rxHdrLimitOut == mHA, {req, " hdr offered"}, int'(rxHdrLimitOut), int'(mHA));
    chk(rxDatLimitOut == mDA, {req, " dat offered"}, int'(rxDatLimitOut), int'(mDA));
    chk(rxUpdValid == expUpd, {req, " upd strobe"}, int'(rxUpdValid), int'(expUpd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1 and R10: reset state
    repeat (3) @(negedge clk);
    txReqValid = 1'b1;
    #1;
    chk(txReady == 1'b0, "R1 ready in reset", int'(txReady), 0);
    chk(txHdrAvail == '0, "R1 hdr avail", int'(txHdrAvail), 0);
    chk(txDatAvail == '0, "R1 dat avail", int'(txDatAvail), 0);
    chk(rxHdrLimitOut == HW'(HCAP), "R1 hdr offered", int'(rxHdrLimitOut), HCAP);
    chk(rxDatLimitOut == DW'(DCAP), "R1 dat offered", int'(rxDatLimitOut), DCAP);
    chk(rxHdrRcvd == '0 && rxDatRcvd == '0, "R1 rcvd", int'(rxHdrRcvd), 0);
    txReqValid = 1'b0;
    rstN = 1'b1;
    #1;
    chk(rxUpdValid == 1'b1, "R10 initial advert", int'(rxUpdValid), 1);
    txStep(1'b1, 0, 1'b0, '0, '0, "R1 no credit");
    chk(rxUpdValid == 1'b0, "R10 advert ends", int'(rxUpdValid), 0);

    // R11: worked example
    txStep(1'b0, 0, 1'b1, 8'd4, 12'd40, "R11 grant");
    txStep(1'b1, 160, 1'b0, '0, '0, "R11 send1");
    txStep(1'b1, 160, 1'b0, '0, '0, "R11 send2");
    chk(txHdrAvail == 8'd2, "R11 hdr left", int'(txHdrAvail), 2);
    chk(txDatAvail == 12'd20, "R11 dat left", int'(txDatAvail), 20);

    // R3: every header offset, data ample
    for (int d = 0; d < 256; d++) begin
      txStep(1'b0, 0, 1'b1, mHC + HW'(d), mDC + DW'(100), "R3 hdr set");
      txStep(1'b1, 0, 1'b0, '0, '0, "R3 hdr window");
    end
    // R3: data window, both ends of the half range
    for (int d = 0; d < 300; d++) begin
      txStep(1'b0, 0, 1'b1, mHC + HW'(5), mDC + DW'(d), "R3 dat set");
      txStep(1'b1, 160, 1'b0, '0, '0, "R3 dat window");
    end
    for (int d = 2040; d < 2060; d++) begin
      txStep(1'b0, 0, 1'b1, mHC + HW'(5), mDC + DW'(d), "R3 dat set hi");
      txStep(1'b1, 160, 1'b0, '0, '0, "R3 dat window hi");
    end

    // R4 blocked: limit equal to spent
    txStep(1'b0, 0, 1'b1, mHC, mDC + DW'(50), "R4 block set");
    txStep(1'b1, 16, 1'b0, '0, '0, "R4 blocked hdr");
    txStep(1'b0, 0, 1'b1, mHC + HW'(3), mDC, "R4 block set dat");
    txStep(1'b1, 1, 1'b0, '0, '0, "R4 blocked dat");
    txStep(1'b1, 0, 1'b0, '0, '0, "R5 zero bytes fits");

    // R4 R5 R6 R7: every size, update each cycle, counters wrap
    txStep(1'b0, 0, 1'b1, mHC + HW'(50), mDC + DW'(1000), "R6 prime");
    for (int b = 0; b < 4096; b++) begin
      txStep(1'b1, b, 1'b1, mHC + HW'(50), mDC + DW'(1000), "R4 R6 R7 size sweep");
    end

    // R8: arriving packets of many sizes, R7 wrap on receive
    for (int b = 0; b < 700; b++) begin
      rxStep(1'b1, b * 5, 1'b0, '0, '0, "R8 R7 receive");
    end
    // R9: frees, empty frees, and mixed cycles
    for (int h = 0; h < 20; h++) begin
      rxStep(1'b0, 0, 1'b1, HW'(h), DW'(h * 37), "R9 free");
      rxStep(1'b0, 0, 1'b0, '0, '0, "R9 idle");
    end
    rxStep(1'b0, 0, 1'b1, '0, '0, "R9 empty free");
    rxStep(1'b1, 33, 1'b1, 8'd0, 12'd9, "R9 R8 mixed");
    for (int h = 0; h < 300; h++) begin
      rxStep(1'b1, 64, 1'b1, 8'd1, 12'd4, "R9 R7 offered wrap");
    end

    finish();
  end

endmodule